// File: doc/BRIEF.md
# Serial Configuration Word Programmer

This block sits on the host side of a three-wire configuration port and sends one wide configuration word to a programmable clock device. The host places the complete word on a parallel input and gives a single-cycle start pulse. The block then shifts the word out on a data line, most significant bit first. It forms a serial clock whose rising edge captures each bit. Every timing gap is counted in cycles of the faster system clock.

When the last bit has been clocked in, the block leaves the serial clock low for a programmable wait. It then raises a load strobe for a programmable width, which commits the shifted word inside the device. After the strobe falls, the block drops its busy flag and gives a one-cycle completion pulse. The strobe is never high while bits are being shifted. The serial clock never rises while the strobe is high. The setup, hold, wait and strobe times are separate parameters, so each one can be sized to the device's minimum at the chosen system clock rate.

Top module: `cfgword_prog`

## Requirements
- R1: After synchronous active-low reset, the serial clock, data, strobe, busy and done outputs are all 0.
- R2: A start pulse seen while idle captures the parallel word. Busy is 1 from the next cycle onward.
- R3: Each transfer gives exactly WORD_W rising serial-clock edges. The data value at the k-th rising edge is word bit WORD_W-1-k, so the most significant bit goes first.
- R4: Before each rising serial-clock edge, the data line holds the new bit for exactly SETUP_CYC cycles (rounded up) with the serial clock low. The data line does not change at the rising edge.
- R5: The serial clock stays high for exactly HOLD_CYC cycles (rounded up). The data line is stable for that whole time and only changes as the clock falls.
- R6: After the last falling serial-clock edge, the serial clock, strobe and data all stay low for exactly WAIT_CYC cycles (rounded up) before the strobe rises.
- R7: The strobe is high for exactly STROBE_CYC cycles (rounded up). The data line is low during the strobe.
- R8: The serial clock and the strobe are never high in the same cycle. The strobe stays low while bits are shifted.
- R9: Busy falls in the same cycle the strobe falls. Done is high for exactly that one cycle, with busy low.
- R10: Start pulses that arrive while busy is high do not change the word being sent or the length of the transfer, and they do not start a second transfer.
- R11: A timing parameter given as 0 is treated as 1 cycle.
- R12: Busy stays high for exactly WORD_W*(SETUP+HOLD)+WAIT+STROBE cycles, using the rounded-up values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send word_i |
| word_i | input | WORD_W | Configuration word, sampled with an accepted start |
| sclk_o | output | 1 | Serial clock; the device captures data on its rising edge |
| din_o | output | 1 | Serial data, most significant bit first |
| cs_o | output | 1 | Load strobe, pulsed high after all bits are shifted |
| busy_o | output | 1 | High from the accepted start until the strobe falls |
| done_o | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench builds the block with the full 132-bit word and with SETUP_CYC set to 0, HOLD_CYC 3, WAIT_CYC 1 and STROBE_CYC 4. The zero setup value tests the round-up to one cycle, which is the tightest setup window. The unequal hold, wait and strobe values mean that swapping any two counter loads changes a measured run length. With the full word width, the bit counter's wrap at the last bit and the exact busy length of 533 cycles can be checked. Start pulses injected at random points in a transfer, including the wait and strobe phases, test that a busy block ignores them.

// File: rtl/cfgprog_pkg.sv
// Package: shared state encoding and parameter helpers for the
// serial configuration word programmer.
package cfgprog_pkg;

    // Sequencer phases, in the order a transfer visits them.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_HIGH   = 3'd2,
        ST_WAIT   = 3'd3,
        ST_STROBE = 3'd4
    } seq_state_t;

    // Clamp a cycle count so that every phase lasts at least one cycle.
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Larger of two counts, used to size the shared phase timer.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgprog_timer.sv
// Module: cfgprog_timer
// Down-counter that measures one phase of the transfer. A load sets it
// to (cycles - 1); expired_o is high while the count is zero, so a
// phase loaded with value v ends after v+1 cycles.
// Assumes: load_i and the value are driven by the sequencer only.
module cfgprog_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_q;

    // Load on phase entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R11: an expired counter with no new load never wraps upward.
    a_r11_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

    // R11: a loaded counter moves down by one each cycle until a new load.
    a_r11_timer_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!expired_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cfgprog_shifter.sv
// Module: cfgprog_shifter
// Holds the word being sent and counts the bits already clocked out.
// The MSB of the register drives the data pin. Zeros are shifted in, so
// the data pin returns low once all bits have gone.
// Assumes: WORD_W >= 2; load and shift are never requested together.
module cfgprog_shifter #(
    parameter int WORD_W = 132
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              msb_o,
    output logic              last_o
);

    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_IDX = BW'(WORD_W - 1);

    logic [WORD_W-1:0] sreg_q;
    logic [BW-1:0]     bitcnt_q;

    // Capture the word on load; move the next bit up to the MSB on shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load_i) begin
            sreg_q <= word_i;
        end else if (shift_i) begin
            sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
        end
    end

    // Count finished bits, clearing on load and wrapping after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
        end else if (load_i) begin
            bitcnt_q <= '0;
        end else if (shift_i) begin
            bitcnt_q <= (bitcnt_q == LAST_IDX) ? '0 : bitcnt_q + 1'b1;
        end
    end

    assign msb_o  = sreg_q[WORD_W-1];
    assign last_o = (bitcnt_q == LAST_IDX);

    // R3: the bit counter never leaves the range of the word.
    a_r3_bitcnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt_q <= LAST_IDX);

    // R3: after the final shift the register is empty, so data idles low.
    a_r3_empty_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && last_o && !load_i) |=> (sreg_q == '0));

    // R10: the sequencer never asks for a reload and a shift in one cycle.
    a_r10_no_load_and_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/cfgprog_seq.sv
// Module: cfgprog_seq
// Transfer sequencer: walks setup/high phases for each bit, then the
// wait gap and the load strobe. It registers the serial clock, strobe,
// busy and done pins from the next state.
// Assumes: the timer and shifter are reset in the same cycle as this.
module cfgprog_seq
    import cfgprog_pkg::*;
#(
    parameter int TW        = 2,
    parameter int SETUP_EFF = 1,
    parameter int HOLD_EFF  = 1,
    parameter int WAIT_EFF  = 1,
    parameter int STROBE_EFF = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tmr_exp_i,
    input  logic          last_bit_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          word_load_o,
    output logic          shift_o,
    output logic          sclk_o,
    output logic          cs_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [TW-1:0] SETUP_LD  = TW'(SETUP_EFF - 1);
    localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_EFF - 1);
    localparam logic [TW-1:0] WAIT_LD   = TW'(WAIT_EFF - 1);
    localparam logic [TW-1:0] STROBE_LD = TW'(STROBE_EFF - 1);

    seq_state_t state_q, state_n;
    logic       done_n;
    logic       sclk_q, cs_q, busy_q, done_q;

    // Next-state and per-phase control: timer loads, word load, shifting.
    always_comb begin
        state_n     = state_q;
        tmr_load_o  = 1'b0;
        tmr_val_o   = '0;
        word_load_o = 1'b0;
        shift_o     = 1'b0;
        done_n      = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_n     = ST_SETUP;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = SETUP_LD;
                    word_load_o = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_exp_i) begin
                    state_n    = ST_HIGH;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HOLD_LD;
                end
            end
            ST_HIGH: begin
                if (tmr_exp_i) begin
                    shift_o    = 1'b1;
                    tmr_load_o = 1'b1;
                    if (last_bit_i) begin
                        state_n   = ST_WAIT;
                        tmr_val_o = WAIT_LD;
                    end else begin
                        state_n   = ST_SETUP;
                        tmr_val_o = SETUP_LD;
                    end
                end
            end
            ST_WAIT: begin
                if (tmr_exp_i) begin
                    state_n    = ST_STROBE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = STROBE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_exp_i) begin
                    state_n = ST_IDLE;
                    done_n  = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register plus pin registers decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            cs_q    <= 1'b0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            sclk_q  <= (state_n == ST_HIGH);
            cs_q    <= (state_n == ST_STROBE);
            busy_q  <= (state_n != ST_IDLE);
            done_q  <= done_n;
        end
    end

    assign sclk_o = sclk_q;
    assign cs_o   = cs_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // R8: serial clock and strobe are never high together.
    a_r8_sclk_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_o && cs_o));

    // R2: an accepted start raises busy with the pins still quiet.
    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (busy_o && !sclk_o && !cs_o));

    // R9: done follows the strobe falling, with busy already low.
    a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cs_o) && !cs_o && !busy_o));

    // R9: done is a single-cycle pulse.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a start during a transfer that is not ending leaves busy high.
    a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !done_n) |=> busy_o);

endmodule

// File: rtl/cfgword_prog.sv
// Module: cfgword_prog (top)
// Host-side programmer that sends one WORD_W-bit configuration word,
// most significant bit first, and then pulses a load strobe. Every
// timing parameter is a count of system-clock cycles, rounded up to 1.
// Assumes: start_i is a single-cycle pulse; word_i is valid with it.
module cfgword_prog
    import cfgprog_pkg::*;
#(
    parameter int WORD_W     = 132,
    parameter int SETUP_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int WAIT_CYC   = 1,
    parameter int STROBE_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sclk_o,
    output logic              din_o,
    output logic              cs_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int SETUP_EFF  = at_least_one(SETUP_CYC);
    localparam int HOLD_EFF   = at_least_one(HOLD_CYC);
    localparam int WAIT_EFF   = at_least_one(WAIT_CYC);
    localparam int STROBE_EFF = at_least_one(STROBE_CYC);
    localparam int MAX_EFF    = max2(max2(SETUP_EFF, HOLD_EFF), max2(WAIT_EFF, STROBE_EFF));
    localparam int TW         = (MAX_EFF > 1) ? $clog2(MAX_EFF) : 1;

    logic          tmr_load, tmr_exp;
    logic [TW-1:0] tmr_val;
    logic          word_load, shift, last_bit, msb;

    cfgprog_seq #(
        .TW        (TW),
        .SETUP_EFF (SETUP_EFF),
        .HOLD_EFF  (HOLD_EFF),
        .WAIT_EFF  (WAIT_EFF),
        .STROBE_EFF(STROBE_EFF)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tmr_exp_i  (tmr_exp),
        .last_bit_i (last_bit),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .word_load_o(word_load),
        .shift_o    (shift),
        .sclk_o     (sclk_o),
        .cs_o       (cs_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    cfgprog_timer #(
        .TW(TW)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .val_i    (tmr_val),
        .expired_o(tmr_exp)
    );

    cfgprog_shifter #(
        .WORD_W(WORD_W)
    ) shifter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (word_load),
        .word_i (word_i),
        .shift_i(shift),
        .msb_o  (msb),
        .last_o (last_bit)
    );

    assign din_o = msb;

    // R4: data does not move on the cycle the serial clock rises.
    a_r4_din_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(din_o));

    // R5: data holds while the serial clock stays high.
    a_r5_din_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(din_o));

    // R7: data is low while the load strobe is high.
    a_r7_din_low_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> !din_o);

    // R1: nothing toggles on the pins while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!sclk_o && !cs_o && !din_o));

endmodule

// File: tb/cfgword_prog_tb_top.sv
// Bench: drives words with random and directed patterns, monitors the
// serial pins each cycle on the falling clock edge and checks the
// measured runs against values computed from the requirements.
module cfgword_prog_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 132;
    localparam int P_SETUP    = 0;
    localparam int P_HOLD     = 3;
    localparam int P_WAIT     = 1;
    localparam int P_STROBE   = 4;

    function automatic int eff(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic int exp_busy();
        return N * (eff(P_SETUP) + eff(P_HOLD)) + eff(P_WAIT) + eff(P_STROBE);
    endfunction

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [N-1:0] word = '0;
    logic         sclk, din, cs, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgword_prog #(
        .WORD_W    (N),
        .SETUP_CYC (P_SETUP),
        .HOLD_CYC  (P_HOLD),
        .WAIT_CYC  (P_WAIT),
        .STROBE_CYC(P_STROBE)
    ) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .word_i (word),
        .sclk_o (sclk),
        .din_o  (din),
        .cs_o   (cs),
        .busy_o (busy),
        .done_o (done)
    );

    task automatic check(input bit ok, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // One transfer; a stray start is injected at sample inject_at (-1: none).
    task automatic run_word(input logic [N-1:0] w, input int inject_at,
                            input logic [N-1:0] other);
        logic [N-1:0] rx = '0;
        int  rises = 0, low_run = 0, high_run = 0, gap_run = 0, cs_run = 0;
        int  busy_n = 0, v_setup = 0, v_hold = 0, v_gap = 0, v_cs = 0, v_excl = 0;
        int  guard = 0;
        bit  done_seen = 1'b0, done_ok = 1'b0, first_busy = 1'b0;
        logic prev_din = 1'b0, prev_sclk = 1'b0;

        @(negedge clk);
        start = 1'b1;
        word  = w;
        @(negedge clk);
        start = 1'b0;
        while (!done_seen && guard < 5000) begin
            if (guard == inject_at) begin
                start = 1'b1;
                word  = other;
            end else begin
                start = 1'b0;
            end
            if (guard == 0) first_busy = busy;
            if (busy) busy_n++;
            if (sclk && cs) v_excl++;
            if (done) begin
                done_seen = 1'b1;
                done_ok   = !busy && !cs && !sclk && !din;
            end else if (cs) begin
                cs_run++;
                if (din) v_cs++;
            end else if (sclk || rises < N) begin
                if (sclk) begin
                    if (!prev_sclk) begin
                        rises++;
                        rx = {rx[N-2:0], din};
                        if (low_run != eff(P_SETUP)) v_setup++;
                        if (din != prev_din) v_setup++;
                        low_run  = 0;
                        high_run = 1;
                    end else begin
                        high_run++;
                        if (din != prev_din) v_hold++;
                    end
                end else begin
                    if (prev_sclk) begin
                        if (high_run != eff(P_HOLD)) v_hold++;
                    end else if (low_run > 0 && din != prev_din) begin
                        v_setup++;
                    end
                    low_run++;
                end
            end else begin
                if (prev_sclk && high_run != eff(P_HOLD)) v_hold++;
                gap_run++;
                if (din) v_gap++;
            end
            prev_din  = din;
            prev_sclk = sclk;
            guard++;
            @(negedge clk);
        end
        start = 1'b0;
        check(first_busy, "R2 busy after accepted start", N'(first_busy), N'(1));
        check(rx == w, "R3 R10 received word", rx, w);
        check(rises == N, "R3 rising edge count", N'(rises), N'(N));
        check(v_setup == 0, "R4 R11 setup run and stability", N'(v_setup), N'(0));
        check(v_hold == 0, "R5 high run and hold stability", N'(v_hold), N'(0));
        check(gap_run == eff(P_WAIT) && v_gap == 0, "R6 wait gap before strobe",
              N'(gap_run), N'(eff(P_WAIT)));
        check(cs_run == eff(P_STROBE) && v_cs == 0, "R7 strobe width",
              N'(cs_run), N'(eff(P_STROBE)));
        check(v_excl == 0, "R8 clock and strobe overlap", N'(v_excl), N'(0));
        check(busy_n == exp_busy(), "R12 R10 busy length", N'(busy_n), N'(exp_busy()));
        check(done_seen && done_ok, "R9 done pulse with busy low",
              N'({done_seen, done_ok}), N'(3));
        // Sample taken here is the cycle after done.
        check(!done && !busy && !cs && !sclk, "R9 R10 quiet after done",
              N'({done, busy, cs, sclk}), N'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] w, o;
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        start = 1'b1;
        word  = {N{1'b1}};
        repeat (4) @(negedge clk);
        // R1: outputs quiet during and just after reset, start ignored.
        check({sclk, din, cs, busy, done} == 5'b0, "R1 reset outputs",
              N'({sclk, din, cs, busy, done}), N'(0));
        start = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check({sclk, din, cs, busy, done} == 5'b0, "R1 idle after reset",
              N'({sclk, din, cs, busy, done}), N'(0));

        // Directed patterns.
        run_word('0, -1, '0);
        run_word({N{1'b1}}, 10, '0);
        run_word({1'b1, {(N-1){1'b0}}}, exp_busy() - 2, {N{1'b1}});
        for (int k = 0; k < N; k++) w[k] = k[0];
        run_word(w, exp_busy() - eff(P_STROBE) - 1, ~w);
        run_word({{(N-1){1'b0}}, 1'b1}, 0, {N{1'b1}});

        // Random words with random stray starts.
        for (int t = 0; t < 12; t++) begin
            for (int k = 0; k < N; k++) begin
                w[k] = 1'($urandom_range(0, 1));
                o[k] = 1'($urandom_range(0, 1));
            end
            run_word(w, (t % 3 == 0) ? -1 : int'($urandom_range(0, exp_busy() - 1)), o);
            repeat (int'($urandom_range(0, 3))) @(negedge clk);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule